// File: doc/BRIEF.md
# Parallel ATA Device Register File

This block is the register file on the device side of a parallel ATA (IDE) target. It takes the host's chip selects, register address and active-low read and write strobes, passes them through a clock-domain synchronizer, and gives the host access to the command block registers and the control block registers. The device logic sits on the other side. It sees every parameter register as a plain output and receives a one-cycle pulse whenever a command byte lands. It drives status bits through set and clear vectors, loads error codes, and raises a pending-interrupt flag when a command finishes or a data block is ready.

The data register is not stored in this block. Word reads return the value on an external buffer port, and each completed data access produces a one-cycle read or write pulse toward that buffer. Soft reset is requested through a bit of the control register and is shown to the device as a level. Hardware reset is the host's active-low reset pin. That pin is asserted asynchronously and released through a synchronizer.

Top module: `ide_taskfile`

## Requirements
- R1: With `cs0_n` low and `cs1_n` high, `addr` selects a command block register. The codes are 0 data, 1 error (read) / feature (write), 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, and 7 status (read) / command (write). With `cs1_n` low and `cs0_n` high, code 6 reads alternate status and writes device control, and code 7 reads the drive address register. `dout_oe` is high only while `rd_n` is low on one of these selections.
- R2: A host write takes effect on the rising (trailing) edge of `wr_n`. The register is unchanged while `wr_n` is low, and the new value appears within three clock cycles after `wr_n` rises.
- R3: Register reads drive only `dout[7:0]`, and `dout[15:8]` reads as 0. A read of the data register returns all 16 bits of `buf_rdata`. `iois16_n` is low exactly while the data register is selected.
- R4: The status byte has BUSY at bit 7, RDY at 6, DWF at 5, DSC at 4, DRQ at 3, CORR at 2 and ERR at 0, and bit 1 always reads 0. In each cycle a bit is set by `dev_set` and cleared by `dev_clr`. Clear wins when both are applied to the same bit.
- R5: While BUSY is 1, host writes to all command block registers (data and command included) are ignored. Device control writes are still accepted.
- R6: A host read of status (code 7) clears the pending interrupt. A read of alternate status returns the same byte and leaves the pending interrupt unchanged.
- R7: `irq` is high when an interrupt is pending and device control bit 1 (interrupt mask) is 0. `intr_set` makes an interrupt pending.
- R8: While device control bit 2 is 1, `soft_rst` is high, status is held at 0x80, the error register is held at 0x01 and no interrupt is pending. Parameter registers keep their values.
- R9: Hardware reset sets status to 0x80 and the error register to 0x01. It clears the interrupt mask, soft reset, all parameter registers and any pending interrupt.
- R10: Drive/head reads back bits 7 and 5 as 1. Bit 6 is the LBA select (`tf_lba`), bit 4 is the drive (`tf_drive`) and bits 3..0 are the head (`tf_head`).
- R11: `err_load` loads `err_code` into the error register, keeping only bits 7, 6, 4, 2 and 0 (mask 0xD5). The remaining bits read 0.
- R12: The drive address register reads bit 7 as 0 and bit 6 as NOT `media_writing`. Bits 5..2 are the inverted head bits. Bit 1 is low when drive 1 is selected and bit 0 is low when drive 0 is selected.
- R13: A command write pulses `cmd_wr` for one cycle with `cmd_code` holding the byte. Each data-register write gives one `buf_wr` pulse with `buf_wdata` holding the word. Each data-register read gives one `buf_rd` pulse after `rd_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| hrst_n | input | 1 | Host hardware reset, active low |
| cs0_n | input | 1 | Command block select, active low |
| cs1_n | input | 1 | Control block select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| din | input | 16 | Host write data |
| dout | output | 16 | Host read data |
| dout_oe | output | 1 | Read data drive enable |
| iois16_n | output | 1 | Low when a word transfer is expected |
| irq | output | 1 | Interrupt request, active high |
| dev_set | input | 8 | Status bits to set this cycle |
| dev_clr | input | 8 | Status bits to clear this cycle |
| err_load | input | 1 | Load the error register |
| err_code | input | 8 | Error byte to load |
| intr_set | input | 1 | Make an interrupt pending |
| media_writing | input | 1 | Media write in progress |
| buf_rdata | input | 16 | Word from the external data buffer |
| buf_rd | output | 1 | Data word consumed by the host |
| buf_wr | output | 1 | Data word written by the host |
| buf_wdata | output | 16 | Word written by the host |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count register |
| tf_sector | output | 8 | Sector number register |
| tf_cyl | output | 16 | Cylinder high and low registers |
| tf_lba | output | 1 | LBA addressing selected |
| tf_drive | output | 1 | Drive select bit |
| tf_head | output | 4 | Head or upper address bits |
| cmd_code | output | 8 | Last command byte |
| cmd_wr | output | 1 | Command written pulse |
| soft_rst | output | 1 | Soft reset level |

## Verification
A wrong internal state shows up at the host read port on the next status or alternate-status read. Because every write lands no later than three clocks after the strobe rises, a read started after that window already exposes a lost, blocked or stray update. A stale pending flag shows on `irq` one clock after the cause, so the pulse, the mask bit and the two status reads can each be checked from the port alone. Soft-reset behaviour becomes visible as soon as the control write lands: status and error freeze at their reset bytes, device set and clear inputs have no effect, and the parameter registers are read back unchanged.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int unsigned BYTE_W = 8;

  // command block register codes (cs0 side)
  localparam logic [2:0] A_DATA    = 3'd0;
  localparam logic [2:0] A_ERRFEAT = 3'd1;
  localparam logic [2:0] A_COUNT   = 3'd2;
  localparam logic [2:0] A_SECTOR  = 3'd3;
  localparam logic [2:0] A_CYLLO   = 3'd4;
  localparam logic [2:0] A_CYLHI   = 3'd5;
  localparam logic [2:0] A_DEVHEAD = 3'd6;
  localparam logic [2:0] A_STATCMD = 3'd7;

  // control block register codes (cs1 side)
  localparam logic [2:0] A_CTL     = 3'd6;
  localparam logic [2:0] A_DRVADDR = 3'd7;

  // status bit positions
  localparam int unsigned S_BSY = 7;
  localparam int unsigned S_DRQ = 3;
  localparam int unsigned S_ERR = 0;

  // device control bit positions
  localparam int unsigned DC_SRST = 2;
  localparam int unsigned DC_NIEN = 1;

  localparam logic [BYTE_W-1:0] STAT_MASK      = 8'hFD;
  localparam logic [BYTE_W-1:0] STAT_AFTER_RST = 8'h80;
  localparam logic [BYTE_W-1:0] ERR_MASK       = 8'hD5;
  localparam logic [BYTE_W-1:0] ERR_AFTER_RST  = 8'h01;
  localparam logic [BYTE_W-1:0] DEVHEAD_ONES   = 8'hA0;
endpackage

// File: rtl/tf_strobe_sync.sv
module tf_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic lead,
  output logic trail
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], strobe_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] the one before it
  assign lead  =  sh_q[STAGES] & ~sh_q[STAGES-1];
  assign trail = ~sh_q[STAGES] &  sh_q[STAGES-1];
endmodule

// File: rtl/tf_regs.sv
module tf_regs #(
  parameter int W  = 8,
  parameter int N  = 8,
  parameter int SW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SW-1:0]        sel,
  input  logic [W-1:0]         wdata,
  output logic [N-1:1][W-1:0]  regs_q,
  output logic                 cmd_pulse
);
  localparam logic [SW-1:0] LAST = SW'(N-1);

  logic [N-1:1][W-1:0] regs_d;
  logic                cmd_d;

  // code 0 is the data port and has no storage here
  for (genvar g = 1; g < N; g++) begin : g_reg
    always_comb begin
      regs_d[g] = regs_q[g];
      if (wr_en && (sel == SW'(g))) regs_d[g] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= regs_d[g];
    end
  end

  always_comb begin
    cmd_d = wr_en && (sel == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_pulse <= 1'b0;
    else        cmd_pulse <= cmd_d;
  end
endmodule

// File: rtl/tf_status.sv
module tf_status
  import tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic [BYTE_W-1:0] st_set,
  input  logic [BYTE_W-1:0] st_clr,
  input  logic              err_load,
  input  logic [BYTE_W-1:0] err_code,
  input  logic              intr_set,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] stat_q,
  output logic [BYTE_W-1:0] err_q,
  output logic              pend_q
);
  logic [BYTE_W-1:0] stat_d;
  logic [BYTE_W-1:0] err_d;
  logic              pend_d;

  always_comb begin
    if (srst) begin
      stat_d = STAT_AFTER_RST;
      err_d  = ERR_AFTER_RST;
      pend_d = 1'b0;
    end else begin
      stat_d = ((stat_q | st_set) & ~st_clr) & STAT_MASK;
      err_d  = err_load ? (err_code & ERR_MASK) : err_q;
      if (intr_set)     pend_d = 1'b1;
      else if (stat_rd) pend_d = 1'b0;
      else              pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_AFTER_RST;
      err_q  <= ERR_AFTER_RST;
      pend_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ide_taskfile.sv
module ide_taskfile
  import tf_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic          clk,
  input  logic          hrst_n,
  input  logic          cs0_n,
  input  logic          cs1_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          iois16_n,
  output logic          irq,
  input  logic [7:0]    dev_set,
  input  logic [7:0]    dev_clr,
  input  logic          err_load,
  input  logic [7:0]    err_code,
  input  logic          intr_set,
  input  logic          media_writing,
  input  logic [DW-1:0] buf_rdata,
  output logic          buf_rd,
  output logic          buf_wr,
  output logic [DW-1:0] buf_wdata,
  output logic [7:0]    tf_feature,
  output logic [7:0]    tf_count,
  output logic [7:0]    tf_sector,
  output logic [15:0]   tf_cyl,
  output logic          tf_lba,
  output logic          tf_drive,
  output logic [3:0]    tf_head,
  output logic [7:0]    cmd_code,
  output logic          cmd_wr,
  output logic          soft_rst
);
  localparam int NREG = 1 << AW;

  // reset: asynchronous assertion, synchronous release
  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_i;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) rs_q <= '0;
    else         rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i = rs_q[RST_STAGES-1];

  // strobe synchronizers
  logic rd_lead, rd_trail, wr_lead, wr_trail;

  tf_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_i), .strobe_n(rd_n), .lead(rd_lead), .trail(rd_trail)
  );
  tf_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_i), .strobe_n(wr_n), .lead(wr_lead), .trail(wr_trail)
  );

  // decode
  logic sel_cmd, sel_ctl, busy;
  logic wr_cmd, wr_ctl, stat_rd;
  logic [BYTE_W-1:0] stat_q, err_q;
  logic pend_q;

  assign sel_cmd = !cs0_n &&  cs1_n;
  assign sel_ctl =  cs0_n && !cs1_n;
  assign busy    = stat_q[S_BSY];
  assign wr_cmd  = wr_trail && sel_cmd && !busy;
  assign wr_ctl  = wr_trail && sel_ctl && (addr == A_CTL);
  assign stat_rd = rd_lead && sel_cmd && (addr == A_STATCMD);

  // device control and data-port pulses
  logic nien_q, srst_q, nien_d, srst_d;
  logic rdflag_q, rdflag_d, bufrd_q, bufrd_d, bufwr_q, bufwr_d;
  logic [DW-1:0] bwd_q, bwd_d;

  always_comb begin
    nien_d   = nien_q;
    srst_d   = srst_q;
    if (wr_ctl) begin
      nien_d = din[DC_NIEN];
      srst_d = din[DC_SRST];
    end
    rdflag_d = rd_lead ? (sel_cmd && (addr == A_DATA)) : rdflag_q;
    bufrd_d  = rd_trail && rdflag_q;
    bufwr_d  = wr_cmd && (addr == A_DATA);
    bwd_d    = bufwr_d ? din : bwd_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      nien_q   <= 1'b0;
      srst_q   <= 1'b0;
      rdflag_q <= 1'b0;
      bufrd_q  <= 1'b0;
      bufwr_q  <= 1'b0;
      bwd_q    <= '0;
    end else begin
      nien_q   <= nien_d;
      srst_q   <= srst_d;
      rdflag_q <= rdflag_d;
      bufrd_q  <= bufrd_d;
      bufwr_q  <= bufwr_d;
      bwd_q    <= bwd_d;
    end
  end

  // parameter registers
  logic [NREG-1:1][BYTE_W-1:0] regs_q;

  tf_regs #(.W(BYTE_W), .N(NREG)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_cmd), .sel(addr), .wdata(din[BYTE_W-1:0]),
    .regs_q(regs_q), .cmd_pulse(cmd_wr)
  );

  tf_status u_status (
    .clk(clk), .rst_n(rst_i), .srst(srst_q), .st_set(dev_set), .st_clr(dev_clr),
    .err_load(err_load), .err_code(err_code), .intr_set(intr_set), .stat_rd(stat_rd),
    .stat_q(stat_q), .err_q(err_q), .pend_q(pend_q)
  );

  logic [BYTE_W-1:0] dh;
  assign dh = regs_q[A_DEVHEAD];

  // host read path
  logic [DW-1:0] rd_val;
  logic          rd_hit;

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    if (sel_cmd) begin
      rd_hit = 1'b1;
      case (addr)
        A_DATA:    rd_val = buf_rdata;
        A_ERRFEAT: rd_val[BYTE_W-1:0] = err_q;
        A_DEVHEAD: rd_val[BYTE_W-1:0] = dh | DEVHEAD_ONES;
        A_STATCMD: rd_val[BYTE_W-1:0] = stat_q;
        default:   rd_val[BYTE_W-1:0] = regs_q[addr];
      endcase
    end else if (sel_ctl) begin
      if (addr == A_CTL) begin
        rd_hit = 1'b1;
        rd_val[BYTE_W-1:0] = stat_q;
      end else if (addr == A_DRVADDR) begin
        rd_hit = 1'b1;
        rd_val[BYTE_W-1:0] = {1'b0, ~media_writing, ~dh[3:0], ~dh[4], dh[4]};
      end
    end
  end

  assign dout_oe  = !rd_n && rd_hit;
  assign dout     = dout_oe ? rd_val : '0;
  assign iois16_n = !(sel_cmd && (addr == A_DATA));
  assign irq      = pend_q && !nien_q;

  assign buf_rd     = bufrd_q;
  assign buf_wr     = bufwr_q;
  assign buf_wdata  = bwd_q;
  assign tf_feature = regs_q[A_ERRFEAT];
  assign tf_count   = regs_q[A_COUNT];
  assign tf_sector  = regs_q[A_SECTOR];
  assign tf_cyl     = {regs_q[A_CYLHI], regs_q[A_CYLLO]};
  assign tf_lba     = dh[6];
  assign tf_drive   = dh[4];
  assign tf_head    = dh[3:0];
  assign cmd_code   = regs_q[A_STATCMD];
  assign soft_rst   = srst_q;
endmodule

// File: rtl/tf_checker.sv
module tf_checker (
  input logic        clk,
  input logic        rst_i,
  input logic        wr_trail,
  input logic        rd_lead,
  input logic        sel_cmd,
  input logic        sel_ctl,
  input logic        busy,
  input logic        stat_rd,
  input logic        intr_set,
  input logic        pend_q,
  input logic        srst_q,
  input logic        nien_q,
  input logic [7:0]  stat_q,
  input logic [7:0]  err_q,
  input logic        irq,
  input logic        cmd_wr,
  input logic        buf_wr,
  input logic [7:0]  tf_count,
  input logic [7:0]  tf_sector,
  input logic [15:0] tf_cyl,
  input logic [7:0]  tf_feature,
  input logic [7:0]  cmd_code
);
  // R5: host writes to command block bounce off while busy
  p_busy_block_r5: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_trail && sel_cmd && busy) |=>
      ($stable(tf_count) && $stable(tf_sector) && $stable(tf_cyl) &&
       $stable(tf_feature) && $stable(cmd_code) && !cmd_wr && !buf_wr));

  // R6: status read drops the pending flag
  p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (stat_rd && !intr_set) |=> !pend_q);

  // R6: alternate status read keeps the pending flag
  p_alt_keep_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_lead && sel_ctl && !intr_set && !srst_q) |=> $stable(pend_q));

  // R7: an unmasked interrupt reaches the pin one cycle later
  p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (intr_set && !nien_q && !srst_q) |=> irq);

  // R8: soft reset freezes status, error and pending
  p_srst_hold_r8: assert property (@(posedge clk) disable iff (!rst_i)
    srst_q |=> (stat_q == 8'h80 && err_q == 8'h01 && !pend_q));

  // R4: status bit 1 never set
  p_stat_bit1_r4: assert property (@(posedge clk) disable iff (!rst_i)
    !stat_q[1]);

  // R11: reserved error bits stay clear
  p_err_resv_r11: assert property (@(posedge clk) disable iff (!rst_i)
    (err_q & 8'h2A) == 8'h00);

  // R13: command pulse lasts one cycle
  p_cmd_pulse_r13: assert property (@(posedge clk) disable iff (!rst_i)
    cmd_wr |=> !cmd_wr);
endmodule

bind ide_taskfile tf_checker u_chk (
  .clk(clk), .rst_i(rst_i), .wr_trail(wr_trail), .rd_lead(rd_lead),
  .sel_cmd(sel_cmd), .sel_ctl(sel_ctl), .busy(busy), .stat_rd(stat_rd),
  .intr_set(intr_set), .pend_q(pend_q), .srst_q(srst_q), .nien_q(nien_q),
  .stat_q(stat_q), .err_q(err_q), .irq(irq), .cmd_wr(cmd_wr), .buf_wr(buf_wr),
  .tf_count(tf_count), .tf_sector(tf_sector), .tf_cyl(tf_cyl),
  .tf_feature(tf_feature), .cmd_code(cmd_code)
);

// File: tb/tb_ide_taskfile.sv
`timescale 1ns/1ps
module tb_ide_taskfile;
  logic        clk = 1'b0;
  logic        hrst_n;
  logic        cs0_n, cs1_n, rd_n, wr_n;
  logic [2:0]  addr;
  logic [15:0] din, dout, buf_rdata, buf_wdata, tf_cyl;
  logic        dout_oe, iois16_n, irq, err_load, intr_set, media_writing;
  logic [7:0]  dev_set, dev_clr, err_code, tf_feature, tf_count, tf_sector, cmd_code;
  logic        buf_rd, buf_wr, tf_lba, tf_drive, cmd_wr, soft_rst;
  logic [3:0]  tf_head;

  always #4 clk = ~clk;

  ide_taskfile dut (
    .clk(clk), .hrst_n(hrst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout), .dout_oe(dout_oe),
    .iois16_n(iois16_n), .irq(irq), .dev_set(dev_set), .dev_clr(dev_clr),
    .err_load(err_load), .err_code(err_code), .intr_set(intr_set),
    .media_writing(media_writing), .buf_rdata(buf_rdata), .buf_rd(buf_rd),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .tf_feature(tf_feature),
    .tf_count(tf_count), .tf_sector(tf_sector), .tf_cyl(tf_cyl), .tf_lba(tf_lba),
    .tf_drive(tf_drive), .tf_head(tf_head), .cmd_code(cmd_code), .cmd_wr(cmd_wr),
    .soft_rst(soft_rst)
  );

  int n_total = 0;
  int n_bad   = 0;
  int n_bufrd = 0;
  int n_bufwr = 0;
  int n_cmd   = 0;
  bit finished = 1'b0;
  logic last_io;

  typedef struct {
    string       tag;
    logic [15:0] val;
  } exp_t;

  exp_t        exp_q[$];
  logic [15:0] act_q[$];

  always @(posedge clk) begin
    if (buf_rd) n_bufrd++;
    if (buf_wr) n_bufwr++;
    if (cmd_wr) n_cmd++;
  end

  // scoreboard monitor: compares host reads against expected items
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        exp_t        e;
        logic [15:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_total++;
        if (a !== e.val) begin
          n_bad++;
          $display("FAIL %s read got=%h exp=%h", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_total++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic host_wr(input bit ctl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cs0_n = ctl; cs1_n = !ctl; addr = a; din = d;
    @(negedge clk);
    wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
    cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  task automatic host_rd(input bit ctl, input logic [2:0] a, input logic [15:0] exp,
                         input string tag);
    exp_t e;
    e.tag = tag; e.val = exp;
    exp_q.push_back(e);
    @(negedge clk);
    cs0_n = ctl; cs1_n = !ctl; addr = a;
    @(negedge clk);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    act_q.push_back(dout);
    last_io = iois16_n;
    rd_n = 1'b1;
    repeat (5) @(negedge clk);
    cs0_n = 1'b1; cs1_n = 1'b1;
  endtask

  task automatic pulse_set(input logic [7:0] s, input logic [7:0] c);
    @(negedge clk); dev_set = s; dev_clr = c;
    @(negedge clk); dev_set = '0; dev_clr = '0;
  endtask

  task automatic pulse_intr();
    @(negedge clk); intr_set = 1'b1;
    @(negedge clk); intr_set = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_total++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    hrst_n = 1'b0; cs0_n = 1'b1; cs1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; din = '0; dev_set = '0; dev_clr = '0; err_load = 1'b0;
    err_code = '0; intr_set = 1'b0; media_writing = 1'b0; buf_rdata = 16'h0000;
    repeat (5) @(negedge clk);
    hrst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 irq", {15'd0, irq}, 16'd0);
    chk("R1 oe idle", {15'd0, dout_oe}, 16'd0);
    chk("R3 iois16 idle", {15'd0, iois16_n}, 16'd1);
    host_rd(1'b0, 3'd7, 16'h0080, "R9 status");
    host_rd(1'b0, 3'd1, 16'h0001, "R9 error");

    // R5 writes blocked while busy, device control still accepted
    host_wr(1'b0, 3'd2, 16'h0055);
    host_wr(1'b1, 3'd6, 16'h0002);
    pulse_set(8'h00, 8'h80);
    host_rd(1'b0, 3'd2, 16'h0000, "R5 count blocked");
    host_rd(1'b0, 3'd7, 16'h0000, "R5 status idle");

    // R7 masking
    pulse_intr();
    chk("R7 masked irq", {15'd0, irq}, 16'd0);
    host_wr(1'b1, 3'd6, 16'h0000);
    chk("R7 unmasked irq", {15'd0, irq}, 16'd1);

    // R6 alternate status leaves interrupt, status clears it
    host_rd(1'b1, 3'd6, 16'h0000, "R6 alt status");
    chk("R6 irq after alt", {15'd0, irq}, 16'd1);
    host_rd(1'b0, 3'd7, 16'h0000, "R6 status");
    chk("R6 irq after status", {15'd0, irq}, 16'd0);

    // R4 status bits
    pulse_set(8'h5A, 8'h00);
    host_rd(1'b0, 3'd7, 16'h0058, "R4 set bits");
    pulse_set(8'h04, 8'h04);
    host_rd(1'b1, 3'd6, 16'h0058, "R4 clear wins");
    pulse_set(8'h00, 8'h08);
    host_rd(1'b1, 3'd6, 16'h0050, "R4 clear drq");

    // R2 write lands on trailing edge
    @(negedge clk);
    cs0_n = 1'b0; cs1_n = 1'b1; addr = 3'd2; din = 16'h0012;
    @(negedge clk);
    wr_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R2 no change while low", {8'd0, tf_count}, 16'h0000);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 after trailing edge", {8'd0, tf_count}, 16'h0012);
    cs0_n = 1'b1;

    // R1 register map
    host_wr(1'b0, 3'd3, 16'h0034);
    host_wr(1'b0, 3'd4, 16'h0056);
    host_wr(1'b0, 3'd5, 16'h0078);
    host_wr(1'b0, 3'd1, 16'h009A);
    host_rd(1'b0, 3'd3, 16'h0034, "R1 sector");
    host_rd(1'b0, 3'd4, 16'h0056, "R1 cyl low");
    host_rd(1'b0, 3'd5, 16'h0078, "R1 cyl high");
    host_rd(1'b0, 3'd2, 16'h0012, "R1 count");
    chk("R1 cyl port", tf_cyl, 16'h7856);
    chk("R1 feature port", {8'd0, tf_feature}, 16'h009A);

    // R10 drive/head
    host_wr(1'b0, 3'd6, 16'h000B);
    host_rd(1'b0, 3'd6, 16'h00AB, "R10 devhead chs");
    host_wr(1'b0, 3'd6, 16'h005A);
    host_rd(1'b0, 3'd6, 16'h00FA, "R10 devhead lba");
    chk("R10 fields", {10'd0, tf_lba, tf_drive, tf_head}, {10'd0, 1'b1, 1'b1, 4'hA});

    // R12 drive address
    host_rd(1'b1, 3'd7, 16'h0055, "R12 drive addr");
    media_writing = 1'b1;
    host_rd(1'b1, 3'd7, 16'h0015, "R12 drive addr writing");
    media_writing = 1'b0;

    // R3 / R13 data port
    buf_rdata = 16'hBEEF;
    host_rd(1'b0, 3'd0, 16'hBEEF, "R3 data word");
    chk("R3 iois16 data", {15'd0, last_io}, 16'd0);
    chk("R13 buf_rd count", n_bufrd[15:0], 16'd1);
    host_rd(1'b0, 3'd7, 16'h0050, "R3 status upper zero");
    chk("R3 iois16 status", {15'd0, last_io}, 16'd1);
    host_wr(1'b0, 3'd0, 16'hCAFE);
    chk("R13 buf_wr count", n_bufwr[15:0], 16'd1);
    chk("R13 buf_wdata", buf_wdata, 16'hCAFE);
    host_wr(1'b0, 3'd7, 16'h0020);
    chk("R13 cmd count", n_cmd[15:0], 16'd1);
    chk("R13 cmd code", {8'd0, cmd_code}, 16'h0020);

    // R11 error mask
    @(negedge clk); err_code = 8'hFF; err_load = 1'b1;
    @(negedge clk); err_load = 1'b0;
    host_rd(1'b0, 3'd1, 16'h00D5, "R11 error mask");

    // R8 soft reset
    pulse_intr();
    chk("R8 irq before", {15'd0, irq}, 16'd1);
    host_wr(1'b1, 3'd6, 16'h0004);
    chk("R8 soft_rst", {15'd0, soft_rst}, 16'd1);
    chk("R8 irq cleared", {15'd0, irq}, 16'd0);
    host_rd(1'b0, 3'd7, 16'h0080, "R8 status held");
    host_rd(1'b0, 3'd1, 16'h0001, "R8 error held");
    pulse_set(8'h00, 8'h80);
    host_rd(1'b1, 3'd6, 16'h0080, "R8 clear ignored");
    chk("R8 count kept", {8'd0, tf_count}, 16'h0012);
    host_wr(1'b1, 3'd6, 16'h0000);
    host_rd(1'b0, 3'd7, 16'h0080, "R8 busy after release");
    pulse_set(8'h00, 8'h80);
    host_rd(1'b0, 3'd7, 16'h0000, "R8 ready again");

    // R9 hardware reset clears the mask and registers
    host_wr(1'b1, 3'd6, 16'h0002);
    @(negedge clk); hrst_n = 1'b0;
    repeat (3) @(negedge clk); hrst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 count cleared", {8'd0, tf_count}, 16'h0000);
    host_rd(1'b0, 3'd7, 16'h0080, "R9 status after hw reset");
    pulse_set(8'h00, 8'h80);
    pulse_intr();
    chk("R9 mask cleared", {15'd0, irq}, 16'd1);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_total++; n_bad++;
      $display("FAIL scoreboard left=%0d exp=0", exp_q.size());
    end
    finished = 1'b1;
    finish_run();
  end
endmodule